// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch

This block picks one of several mutually asynchronous clock inputs and passes it to a single output clock. The choice follows a select input that is synchronous to a slow reference clock. When the select value changes, the block moves from the old source to the new one without a runt pulse. The old source's gate is closed on that source's own falling edge. The sequencer confirms that the gate is closed through synchronizers, and only then asks the new source's gate to open, again on that source's falling edge. The output therefore stays low for a while during every change.

Sources marked as PLL outputs in a parameter mask are not engaged until their lock indication is seen. If lock never arrives within a parameterized number of reference cycles, the change is abandoned, the output stays quiet and an error flag is raised. Each source lane also runs a liveness handshake with the reference domain. A lane whose clock stops while it is engaged or requested, for example a clock stuck high, is forced low asynchronously after a parameterized number of reference cycles (32 by default). This keeps the output from staying high and keeps the sequencer from deadlocking.

Top module: `clk_src_switch`

## Requirements
- R1: The output clock never shows a high or low phase shorter than half the period of the fastest source.
- R2: At most one source gate is open at any time. A new gate is requested only after the old gate is confirmed closed, so every change leaves a low interval on the output.
- R3: After a change to a non-PLL source, `busy` is high during the change and then low. The output then runs at the new source's frequency.
- R4: A select change made while `busy` is high is held and applied after the current change. The last value presented wins.
- R5: For a source whose bit is set in `PLL_MASK` (default 3'b100, source 2), the output stays low and `busy` stays high until `lock_in` for that source is seen high. Only then is the source engaged.
- R6: If lock is not seen within `LOCK_WAIT` reference cycles, `busy` drops, `lock_err` goes high and the output stays low. `lock_err` clears when the next change starts.
- R7: If an engaged source stops toggling for `STALL_LIMIT` reference cycles, its contribution to the output is forced low. A later change away from it completes, and re-selecting it after it recovers engages it again.
- R8: A `sel` value of `N_SRC` or above is ignored: no change starts and the output keeps its source.
- R9: While `rst_n` is low, `clk_out`, `busy` and `lock_err` are low. After release, the source given by `sel` is engaged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Slow reference clock for the sequencer and the watchdogs |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | N_SRC | Candidate clock sources, one bit each |
| lock_in | input | N_SRC | Lock indication per source (used only for PLL-flagged sources) |
| sel | input | SEL_W | Requested source index, synchronous to ref_clk |
| clk_out | output | 1 | Switched output clock |
| busy | output | 1 | High while a change is in progress |
| lock_err | output | 1 | Set when a PLL source failed to lock in time |

## Verification
On every reference cycle the assertions check the following: no two gate acknowledgements are high together, at most one gate request is high, a request rises only once every other gate is acknowledged closed, a PLL lane is requested only with its lock seen, and `busy` falls only with the new gate open, the lane killed, or the lock error raised. Only the bench scenarios can show the following. The output frequency after each change. The absence of runt phases measured in real time. The low gap during handover. A queued select value winning over an earlier one. The stuck-high source being cut off. The lock wait and its timeout seen at the pins.

// File: rtl/csw_pkg.sv
`timescale 1ns/1ps
package csw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DROP  = 2'd1,
    ST_LOCK  = 2'd2,
    ST_RAISE = 2'd3
  } sw_state_e;
endpackage

// File: rtl/csw_rst_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: asserts asynchronously, releases on the local clock.
module csw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/csw_bit_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer.
module csw_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/csw_lane.sv
`timescale 1ns/1ps
// One source lane: falling-edge gate, acknowledge back to the reference
// domain, and a ping/echo liveness check that kills a stalled source.
module csw_lane #(
  parameter int STALL_LIMIT = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic ref_rst_n,
  input  logic arst_n,
  input  logic src_clk,
  input  logic req,
  output logic gclk,
  output logic ack,
  output logic killed
);
  localparam int CNT_W = $clog2(STALL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STALL_LIMIT);

  logic src_rst_n;
  logic lane_clr_n;
  logic req_src;
  logic en_q;
  logic ping_q, ping_d;
  logic echo_src, echo_ref;
  logic req_q;
  logic kill_q, kill_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic alive, active, req_rise;

  csw_rst_sync #(.STAGES(SYNC_STAGES)) u_src_rst (
    .clk(src_clk), .arst_n(arst_n), .rst_n_o(src_rst_n)
  );

  // A killed lane has its source-domain gate path cleared asynchronously.
  assign lane_clr_n = src_rst_n & ~kill_q;

  csw_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(src_clk), .rst_n(lane_clr_n), .d(req), .q(req_src)
  );

  // Gate enable changes only while the source is low.
  always_ff @(negedge src_clk or negedge lane_clr_n) begin
    if (!lane_clr_n) en_q <= 1'b0;
    else             en_q <= req_src;
  end

  assign gclk = src_clk & en_q & ~kill_q;

  csw_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(en_q), .q(ack)
  );

  // Liveness: the source domain echoes the ping; a caught-up echo proves edges.
  csw_bit_sync #(.STAGES(SYNC_STAGES)) u_echo_src (
    .clk(src_clk), .rst_n(src_rst_n), .d(ping_q), .q(echo_src)
  );
  csw_bit_sync #(.STAGES(SYNC_STAGES)) u_echo_ref (
    .clk(ref_clk), .rst_n(ref_rst_n), .d(echo_src), .q(echo_ref)
  );

  always_comb begin
    alive    = (echo_ref == ping_q);
    active   = req | ack;
    req_rise = req & ~req_q;
    ping_d   = alive ? ~ping_q : ping_q;
    cnt_d    = cnt_q;
    if (!active || alive)    cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    kill_d = kill_q;
    if (req_rise)                          kill_d = 1'b0;
    else if (active && (cnt_q == CNT_MAX)) kill_d = 1'b1;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      ping_q <= 1'b0;
      req_q  <= 1'b0;
      kill_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      ping_q <= ping_d;
      req_q  <= req;
      kill_q <= kill_d;
      cnt_q  <= cnt_d;
    end
  end

  // A kill about to be cleared by a fresh request is not reported.
  assign killed = kill_q & ~req_rise;
endmodule

// File: rtl/csw_ctrl.sv
`timescale 1ns/1ps
// Reference-domain sequencer: release old gate, optional lock wait, engage new.
module csw_ctrl
  import csw_pkg::*;
#(
  parameter int                N_SRC     = 3,
  parameter int                SEL_W     = 2,
  parameter logic [N_SRC-1:0]  PLL_MASK  = '0,
  parameter int                LOCK_WAIT = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_SRC-1:0] ack,
  input  logic [N_SRC-1:0] killed,
  input  logic [N_SRC-1:0] lock_s,
  output logic [N_SRC-1:0] req,
  output logic             busy,
  output logic             lock_err
);
  localparam int WAIT_W = (LOCK_WAIT > 1) ? $clog2(LOCK_WAIT) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(LOCK_WAIT - 1);
  localparam logic [SEL_W:0]    SEL_LIM   = (SEL_W+1)'(N_SRC);

  sw_state_e         state_q, state_d;
  logic [SEL_W-1:0]  cur_q, cur_d, tgt_q, tgt_d, pend_q, pend_d;
  logic              vld_q, vld_d;
  logic [N_SRC-1:0]  req_q, req_d;
  logic              err_q, err_d;
  logic [WAIT_W-1:0] wait_q, wait_d;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    tgt_d   = tgt_q;
    vld_d   = vld_q;
    req_d   = req_q;
    err_d   = err_q;
    wait_d  = wait_q;
    pend_d  = ({1'b0, sel} < SEL_LIM) ? sel : pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!vld_q || (pend_q != cur_q)) begin
          req_d[cur_q] = 1'b0;
          err_d        = 1'b0;
          tgt_d        = pend_q;
          state_d      = ST_DROP;
        end
      end
      ST_DROP: begin
        if (!ack[cur_q] || killed[cur_q]) begin
          if (PLL_MASK[tgt_q]) begin
            wait_d  = '0;
            state_d = ST_LOCK;
          end else begin
            req_d[tgt_q] = 1'b1;
            state_d      = ST_RAISE;
          end
        end
      end
      ST_LOCK: begin
        if (lock_s[tgt_q]) begin
          req_d[tgt_q] = 1'b1;
          state_d      = ST_RAISE;
        end else if (wait_q == WAIT_LAST) begin
          err_d   = 1'b1;
          cur_d   = tgt_q;
          vld_d   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end
      ST_RAISE: begin
        if (ack[tgt_q] || killed[tgt_q]) begin
          cur_d   = tgt_q;
          vld_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      tgt_q   <= '0;
      pend_q  <= '0;
      vld_q   <= 1'b0;
      req_q   <= '0;
      err_q   <= 1'b0;
      wait_q  <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      tgt_q   <= tgt_d;
      pend_q  <= pend_d;
      vld_q   <= vld_d;
      req_q   <= req_d;
      err_q   <= err_d;
      wait_q  <= wait_d;
    end
  end

  assign req      = req_q;
  assign busy     = (state_q != ST_IDLE);
  assign lock_err = err_q;
endmodule

// File: rtl/clk_src_switch.sv
`timescale 1ns/1ps
module clk_src_switch #(
  parameter int               N_SRC       = 3,
  parameter int               SEL_W       = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  parameter logic [N_SRC-1:0] PLL_MASK    = 3'b100,
  parameter int               LOCK_WAIT   = 200,
  parameter int               STALL_LIMIT = 32,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_clk,
  input  logic [N_SRC-1:0] lock_in,
  input  logic [SEL_W-1:0] sel,
  output logic             clk_out,
  output logic             busy,
  output logic             lock_err
);
  logic             ref_rst_n;
  logic [N_SRC-1:0] lane_req;
  logic [N_SRC-1:0] lane_ack;
  logic [N_SRC-1:0] lane_kill;
  logic [N_SRC-1:0] lane_gclk;
  logic [N_SRC-1:0] lock_s;

  csw_rst_sync #(.STAGES(SYNC_STAGES)) u_ref_rst (
    .clk(ref_clk), .arst_n(rst_n), .rst_n_o(ref_rst_n)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_lane
    csw_bit_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
      .clk(ref_clk), .rst_n(ref_rst_n), .d(lock_in[i]), .q(lock_s[i])
    );
    csw_lane #(.STALL_LIMIT(STALL_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_lane (
      .ref_clk  (ref_clk),
      .ref_rst_n(ref_rst_n),
      .arst_n   (rst_n),
      .src_clk  (src_clk[i]),
      .req      (lane_req[i]),
      .gclk     (lane_gclk[i]),
      .ack      (lane_ack[i]),
      .killed   (lane_kill[i])
    );
  end

  csw_ctrl #(
    .N_SRC(N_SRC), .SEL_W(SEL_W), .PLL_MASK(PLL_MASK), .LOCK_WAIT(LOCK_WAIT)
  ) u_ctrl (
    .clk     (ref_clk),
    .rst_n   (ref_rst_n),
    .sel     (sel),
    .ack     (lane_ack),
    .killed  (lane_kill),
    .lock_s  (lock_s),
    .req     (lane_req),
    .busy    (busy),
    .lock_err(lock_err)
  );

  assign clk_out = |lane_gclk;
endmodule

// File: rtl/csw_checks.sv
`timescale 1ns/1ps
module csw_checks #(
  parameter int               N_SRC    = 3,
  parameter logic [N_SRC-1:0] PLL_MASK = '0
) (
  input logic             ref_clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] req,
  input logic [N_SRC-1:0] ack,
  input logic [N_SRC-1:0] killed,
  input logic [N_SRC-1:0] lock_s,
  input logic             busy,
  input logic             lock_err
);
  assert_one_gate_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $onehot0(ack));

  assert_one_request_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $countones(req) <= 1);

  assert_raise_after_release_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ((req & ~$past(req)) != '0) |-> ((ack & ~req) == '0));

  assert_busy_end_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $fell(busy) |-> ((|ack) || (|killed) || lock_err));

  assert_err_ends_switch_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(lock_err) |-> !busy);

  for (genvar i = 0; i < N_SRC; i++) begin : g_pll
    if (PLL_MASK[i]) begin : g_on
      assert_lock_before_engage_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(req[i]) |-> lock_s[i]);
    end
  end
endmodule

bind clk_src_switch csw_checks #(.N_SRC(N_SRC), .PLL_MASK(PLL_MASK)) u_checks (
  .ref_clk (ref_clk),
  .rst_n   (ref_rst_n),
  .req     (lane_req),
  .ack     (lane_ack),
  .killed  (lane_kill),
  .lock_s  (lock_s),
  .busy    (busy),
  .lock_err(lock_err)
);

// File: tb/clk_src_switch_test.sv
`timescale 1ns/1ps
module clk_src_switch_test;
  logic       ref_clk;
  logic       rst_n;
  logic [2:0] src_clk;
  logic [2:0] lock_in;
  logic [1:0] sel;
  logic       clk_out, busy, lock_err;

  logic s0, s1, s2;
  logic frz1;

  int total, bad, cyc, edges, runts;
  real t_rise, t_fall, max_low;
  bit  done, saw_busy;

  typedef struct packed {
    logic [1:0] sel;
    logic       lck;
    logic [9:0] lo;
    logic [9:0] hi;
  } vec_t;

  // Expected rising edges in a 2000 ns window: src0 7 ns, src1 11 ns, src2 5 ns.
  localparam vec_t VECS [0:4] = '{
    '{sel: 2'd1, lck: 1'b0, lo: 10'd179, hi: 10'd184},
    '{sel: 2'd2, lck: 1'b1, lo: 10'd397, hi: 10'd402},
    '{sel: 2'd0, lck: 1'b1, lo: 10'd283, hi: 10'd288},
    '{sel: 2'd2, lck: 1'b1, lo: 10'd397, hi: 10'd402},
    '{sel: 2'd1, lck: 1'b0, lo: 10'd179, hi: 10'd184}
  };

  clk_src_switch uut (
    .ref_clk(ref_clk), .rst_n(rst_n), .src_clk(src_clk), .lock_in(lock_in),
    .sel(sel), .clk_out(clk_out), .busy(busy), .lock_err(lock_err)
  );

  initial ref_clk = 1'b0;
  always #10 ref_clk = ~ref_clk;

  initial begin s0 = 1'b0; s1 = 1'b0; s2 = 1'b0; frz1 = 1'b0; end
  always #3.5 s0 = ~s0;
  always begin #5.5; s1 = frz1 ? 1'b1 : ~s1; end
  always #2.5 s2 = ~s2;
  assign src_clk = {s2, s1, s0};

  initial begin edges = 0; runts = 0; t_rise = 0.0; t_fall = 0.0; max_low = 0.0; end
  always @(posedge clk_out) begin
    edges++;
    if (t_fall > 0.0) begin
      if ($realtime - t_fall < 2.4) runts++;
      if ($realtime - t_fall > max_low) max_low = $realtime - t_fall;
    end
    t_rise = $realtime;
  end
  always @(negedge clk_out) begin
    if (t_rise > 0.0 && ($realtime - t_rise < 2.4)) runts++;
    t_fall = $realtime;
  end

  task automatic chk(input string rq, input string what, input int act,
                     input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", rq, what, act, lo, hi);
    end
  endtask

  task automatic measure(output int n);
    int a;
    a = edges;
    #2000;
    n = edges - a;
  endtask

  task automatic settle();
    int quiet, guard;
    quiet = 0; guard = 0; saw_busy = 1'b0;
    while (quiet < 6 && guard < 3000) begin
      @(negedge ref_clk);
      guard++;
      if (busy) begin quiet = 0; saw_busy = 1'b1; end
      else quiet++;
    end
  endtask

  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n, e0;
    total = 0; bad = 0; cyc = 0; done = 1'b0;
    rst_n = 1'b0; sel = 2'd0; lock_in = 3'b000;
    // R9: reset state
    e0 = edges;
    repeat (5) @(negedge ref_clk);
    chk("R9", "edges in reset", edges - e0, 0, 0);
    chk("R9", "busy in reset", int'(busy), 0, 0);
    chk("R9", "lock_err in reset", int'(lock_err), 0, 0);
    rst_n = 1'b1;
    settle();
    measure(n);
    chk("R9", "source 0 after reset", n, 283, 288);

    // Table walk: R3 / R5 / R2
    foreach (VECS[i]) begin
      @(negedge ref_clk);
      lock_in = {VECS[i].lck, 2'b00};
      max_low = 0.0;
      sel = VECS[i].sel;
      settle();
      chk("R3", "busy seen during change", int'(saw_busy), 1, 1);
      chk("R2", "low gap ns during handover", int'(max_low), 20, 100000);
      measure(n);
      chk("R3", "edges after change", n, int'(VECS[i].lo), int'(VECS[i].hi));
      chk("R6", "lock_err after good change", int'(lock_err), 0, 0);
    end

    // R8: out-of-range select ignored (current source 1)
    @(negedge ref_clk);
    sel = 2'd3;
    saw_busy = 1'b0;
    repeat (10) begin @(negedge ref_clk); if (busy) saw_busy = 1'b1; end
    chk("R8", "busy on invalid select", int'(saw_busy), 0, 0);
    measure(n);
    chk("R8", "source kept on invalid select", n, 179, 184);
    sel = 2'd1;
    settle();

    // R4: change queued while busy, last value wins
    @(negedge ref_clk);
    lock_in = 3'b100;
    sel = 2'd0;
    while (!busy) @(negedge ref_clk);
    sel = 2'd2;
    settle();
    measure(n);
    chk("R4", "queued select applied", n, 397, 402);

    // R5: lock wait holds output low, then engages
    @(negedge ref_clk); sel = 2'd0; settle();
    @(negedge ref_clk); lock_in = 3'b000; sel = 2'd2;
    repeat (40) @(negedge ref_clk);
    chk("R5", "busy while waiting for lock", int'(busy), 1, 1);
    e0 = edges;
    #300;
    chk("R5", "edges while waiting for lock", edges - e0, 0, 0);
    lock_in = 3'b100;
    settle();
    measure(n);
    chk("R5", "PLL source after lock", n, 397, 402);
    chk("R5", "no lock error", int'(lock_err), 0, 0);

    // R6: lock timeout
    @(negedge ref_clk); sel = 2'd0; settle();
    @(negedge ref_clk); lock_in = 3'b000; sel = 2'd2;
    repeat (100) @(negedge ref_clk);
    chk("R6", "busy mid lock wait", int'(busy), 1, 1);
    chk("R6", "no error mid lock wait", int'(lock_err), 0, 0);
    settle();
    chk("R6", "lock_err after timeout", int'(lock_err), 1, 1);
    chk("R6", "busy after timeout", int'(busy), 0, 0);
    measure(n);
    chk("R6", "edges after timeout", n, 0, 0);
    @(negedge ref_clk); lock_in = 3'b100; sel = 2'd0;
    settle();
    chk("R6", "lock_err cleared by next change", int'(lock_err), 0, 0);
    measure(n);
    chk("R6", "recovered to source 0", n, 283, 288);

    // R7: stuck-high source forced low
    @(negedge ref_clk); sel = 2'd1; settle();
    frz1 = 1'b1;
    repeat (60) @(negedge ref_clk);
    chk("R7", "output level after stall", int'(clk_out), 0, 0);
    e0 = edges;
    #300;
    chk("R7", "edges after stall", edges - e0, 0, 0);
    @(negedge ref_clk); sel = 2'd0; settle();
    measure(n);
    chk("R7", "switch away from stalled source", n, 283, 288);
    frz1 = 1'b0;
    @(negedge ref_clk); sel = 2'd1; settle();
    measure(n);
    chk("R7", "recovered source re-engaged", n, 179, 184);

    // R1: no runt phases over the whole run
    chk("R1", "runt phases seen", runts, 0, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule